// File: doc/BRIEF.md
# Partial-Access General Register File

This block holds sixteen 64-bit general registers. It serves two combinational read ports and one synchronous write port. Every access carries a 4-bit register code, a 2-bit size and an extension flag. The size codes are 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. The flag matters only for byte accesses, where it picks which byte of which register the code names. The block sits behind an instruction decoder and applies the width rules that a 64-bit variable-length architecture imposes on its integer registers.

Reads return the selected field right-aligned in a 64-bit result, with zeros above it. Writes apply width-dependent rules:

- A 32-bit write clears the upper half of the register.
- A 16-bit write merges into the low 16 bits.
- A byte write merges into the single byte it names.

When the extension flag is clear, byte codes 4 to 7 reach bits 15:8 of the first four registers instead of the low bytes of registers 4 to 7. This gives twenty addressable byte registers in total.

Top module: `gp_regfile`

## Requirements
- R1: After reset, every one of the 16 registers reads as zero at 64-bit size.
- R2: A 64-bit write (size 3) replaces all 64 bits, and a 64-bit read returns the whole register.
- R3: A 32-bit write (size 2) stores wr_data[31:0] into bits 31:0 and clears bits 63:32.
- R4: A 16-bit write (size 1) stores wr_data[15:0] into bits 15:0 and leaves bits 63:16 unchanged.
- R5: A low-byte write stores wr_data[7:0] into bits 7:0 and leaves bits 63:8 unchanged.
- R6: With the flag clear, byte codes 4, 5, 6 and 7 name bits 15:8 of registers 0, 1, 2 and 3. A write to one of these codes stores wr_data[7:0] there and preserves every other bit of every register.
- R7: With the flag set, byte code n (0 to 15) names bits 7:0 of register n.
- R8: With the flag clear, bit 3 of a byte code is ignored, so codes 0 to 3 (and 8 to 11) name bits 7:0 of registers 0 to 3. The flag has no effect on 16, 32 and 64-bit accesses.
- R9: A read of size 8, 16 or 32 returns the field in the low bits with all higher result bits zero.
- R10: A write is visible to reads from the cycle after its clock edge. A read of the same register in the write's own cycle returns the old value.
- R11: The two read ports are independent and may read different registers, sizes and flags in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd0_idx | input | 4 | Read port 0 register code |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_ext | input | 1 | Read port 0 extension flag |
| rd0_data | output | 64 | Read port 0 result |
| rd1_idx | input | 4 | Read port 1 register code |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_ext | input | 1 | Read port 1 extension flag |
| rd1_data | output | 64 | Read port 1 result |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register code |
| wr_size | input | 2 | Write size code |
| wr_ext | input | 1 | Write extension flag |
| wr_data | input | 64 | Write data, right-aligned |

## Verification
A write and a read of the same register can fall in the same cycle. The bench provokes this by holding a write to register 9 on the port while read port 0 addresses register 9 at full width. It samples the read before the clock edge, where the old value is expected, and again after the edge, where the new value is expected. During that same cycle, read port 1 reads an unrelated register and must return that register's own contents.

// File: rtl/gp_regfile.sv
module gp_regfile #(
  parameter int NREG = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  rd0_idx,
  input  logic [1:0]  rd0_size,
  input  logic        rd0_ext,
  output logic [63:0] rd0_data,
  input  logic [3:0]  rd1_idx,
  input  logic [1:0]  rd1_size,
  input  logic        rd1_ext,
  output logic [63:0] rd1_data,
  input  logic        wr_en,
  input  logic [3:0]  wr_idx,
  input  logic [1:0]  wr_size,
  input  logic        wr_ext,
  input  logic [63:0] wr_data
);
  localparam int XW = 64;
  localparam int IW = $clog2(NREG);
  localparam logic [1:0] SZ8  = 2'd0;
  localparam logic [1:0] SZ16 = 2'd1;
  localparam logic [1:0] SZ32 = 2'd2;

  logic [XW-1:0] rf [NREG];

  function automatic logic [IW-1:0] target(input logic [3:0] code, input logic [1:0] size,
                                           input logic ext);
    if (size == SZ8 && !ext) return IW'(code[1:0]);
    return IW'(code);
  endfunction

  function automatic logic is_high(input logic [3:0] code, input logic [1:0] size,
                                   input logic ext);
    return size == SZ8 && !ext && code[2];
  endfunction

  function automatic logic [XW-1:0] rd_fn(input logic [3:0] code, input logic [1:0] size,
                                          input logic ext);
    logic [XW-1:0] v;
    v = rf[target(code, size, ext)];
    case (size)
      SZ8:     return is_high(code, size, ext) ? {56'h0, v[15:8]} : {56'h0, v[7:0]};
      SZ16:    return {48'h0, v[15:0]};
      SZ32:    return {32'h0, v[31:0]};
      default: return v;
    endcase
  endfunction

  assign rd0_data = rd_fn(rd0_idx, rd0_size, rd0_ext);
  assign rd1_data = rd_fn(rd1_idx, rd1_size, rd1_ext);

  logic [IW-1:0] wsel;
  logic [XW-1:0] wold, wnext;

  assign wsel = target(wr_idx, wr_size, wr_ext);
  assign wold = rf[wsel];

  always_comb begin
    case (wr_size)
      SZ8:     wnext = is_high(wr_idx, wr_size, wr_ext) ?
                       {wold[63:16], wr_data[7:0], wold[7:0]} :
                       {wold[63:8], wr_data[7:0]};
      SZ16:    wnext = {wold[63:16], wr_data[15:0]};
      SZ32:    wnext = {32'h0, wr_data[31:0]};
      default: wnext = wr_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (wr_en) begin
      rf[wsel] <= wnext;
    end
  end
endmodule

// File: rtl/gp_regfile_chk.sv
module gp_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  rd0_idx,
  input logic [1:0]  rd0_size,
  input logic        rd0_ext,
  input logic [63:0] rd0_data,
  input logic [1:0]  rd1_size,
  input logic [63:0] rd1_data,
  input logic        wr_en,
  input logic [3:0]  wr_idx,
  input logic [1:0]  wr_size,
  input logic [63:0] wr_data
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  // R2
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(wr_en && wr_size == 2'd3) && rd0_size == 2'd3 && rd0_idx == $past(wr_idx)
    |-> rd0_data == $past(wr_data));

  // R3
  dword_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(wr_en && wr_size == 2'd2) && rd0_size == 2'd3 && rd0_idx == $past(wr_idx)
    |-> rd0_data == {32'h0, $past(wr_data[31:0])});

  // R4
  word_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(wr_en && wr_size == 2'd1 && rd0_size == 2'd3 && rd0_idx == wr_idx)
    && rd0_size == 2'd3 && rd0_idx == $past(wr_idx)
    |-> rd0_data == {$past(rd0_data[63:16]), $past(wr_data[15:0])});

  // R9
  byte_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_size == 2'd0 |-> rd0_data[63:8] == 56'h0);

  // R9
  word_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd1_size == 2'd1 |-> rd1_data[63:16] == 48'h0);

  // R10
  hold_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(wr_en) && $stable(rd0_idx) && $stable(rd0_size) && $stable(rd0_ext)
    |-> $stable(rd0_data));
endmodule

bind gp_regfile gp_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_ext(rd0_ext), .rd0_data(rd0_data),
  .rd1_size(rd1_size), .rd1_data(rd1_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data)
);

// File: tb/gp_regfile_test.sv
`timescale 1ns/1ps
module gp_regfile_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
  logic [1:0] rd0_size = 2'd3, rd1_size = 2'd3, wr_size = 2'd3;
  logic rd0_ext = 1'b0, rd1_ext = 1'b0, wr_ext = 1'b0, wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd0_data, rd1_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gp_regfile uut (.*);

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input int port, input logic [3:0] idx, input logic [1:0] sz,
                    input logic ext, input string tag, input logic [63:0] exp);
    if (port == 0) begin
      rd0_idx = idx; rd0_size = sz; rd0_ext = ext; #1; chk(tag, rd0_data, exp);
    end else begin
      rd1_idx = idx; rd1_size = sz; rd1_ext = ext; #1; chk(tag, rd1_data, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [1:0] sz, input logic ext,
                    input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_size = sz; wr_ext = ext; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 16; i++) rd(i % 2, 4'(i), 2'd3, 1'b0, "R1 reset", 64'h0);
  endtask

  task automatic t_full();
    wr(4'd5, 2'd3, 1'b0, 64'h0123_4567_89AB_CDEF);
    rd(0, 4'd5, 2'd3, 1'b0, "R2 full write", 64'h0123_4567_89AB_CDEF);
    wr(4'd15, 2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(1, 4'd15, 2'd3, 1'b0, "R2 full write port1", 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_dword();
    wr(4'd5, 2'd2, 1'b0, 64'hFFFF_FFFF_1122_3344);
    rd(0, 4'd5, 2'd3, 1'b0, "R3 dword clears top", 64'h0000_0000_1122_3344);
    rd(1, 4'd15, 2'd2, 1'b0, "R9 dword read", 64'h0000_0000_FFFF_FFFF);
  endtask

  task automatic t_word();
    wr(4'd7, 2'd3, 1'b0, 64'hAAAA_BBBB_CCCC_DDDD);
    wr(4'd7, 2'd1, 1'b1, 64'hFFFF_FFFF_FFFF_1234);
    rd(0, 4'd7, 2'd3, 1'b0, "R4 word merge", 64'hAAAA_BBBB_CCCC_1234);
    rd(1, 4'd7, 2'd1, 1'b0, "R9 word read", 64'h1234);
  endtask

  task automatic t_byte_low();
    wr(4'd2, 2'd3, 1'b0, 64'h1111_2222_3333_4444);
    wr(4'd2, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FF5A);
    rd(0, 4'd2, 2'd3, 1'b0, "R5 low byte merge", 64'h1111_2222_3333_445A);
    rd(1, 4'd2, 2'd0, 1'b1, "R9 byte read", 64'h5A);
  endtask

  task automatic t_high();
    wr(4'd6, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFC3);
    rd(0, 4'd2, 2'd3, 1'b0, "R6 high byte of reg2", 64'h1111_2222_3333_C35A);
    rd(1, 4'd6, 2'd0, 1'b0, "R6 high byte read", 64'hC3);
    rd(0, 4'd6, 2'd3, 1'b0, "R6 reg6 untouched", 64'h0);
    wr(4'd7, 2'd0, 1'b0, 64'h77);
    rd(0, 4'd3, 2'd3, 1'b0, "R6 code7 hits reg3", 64'h7700);
    rd(1, 4'd7, 2'd3, 1'b0, "R6 reg7 untouched", 64'hAAAA_BBBB_CCCC_1234);
  endtask

  task automatic t_ext();
    wr(4'd6, 2'd0, 1'b1, 64'h99);
    rd(0, 4'd6, 2'd3, 1'b0, "R7 flag set reg6 low", 64'h99);
    rd(1, 4'd2, 2'd3, 1'b0, "R7 reg2 untouched", 64'h1111_2222_3333_C35A);
    wr(4'd12, 2'd0, 1'b1, 64'hAB);
    rd(0, 4'd12, 2'd0, 1'b1, "R7 reg12 low byte", 64'hAB);
  endtask

  task automatic t_bit3();
    wr(4'd12, 2'd0, 1'b0, 64'h5C);
    rd(0, 4'd0, 2'd3, 1'b0, "R8 code12 flag clear is reg0 high", 64'h5C00);
    rd(1, 4'd12, 2'd3, 1'b0, "R8 reg12 untouched", 64'hAB);
    wr(4'd9, 2'd0, 1'b0, 64'h3E);
    rd(0, 4'd1, 2'd3, 1'b0, "R8 code9 flag clear is reg1 low", 64'h3E);
    rd(1, 4'd5, 2'd3, 1'b1, "R8 flag ignored at 64", 64'h0000_0000_1122_3344);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd9; wr_size = 2'd3; wr_ext = 1'b1; wr_data = 64'hDEAD_BEEF_0000_1111;
    rd0_idx = 4'd9; rd0_size = 2'd3; rd0_ext = 1'b0;
    rd1_idx = 4'd7; rd1_size = 2'd3; rd1_ext = 1'b0;
    #1;
    chk("R10 old value same cycle", rd0_data, 64'h0);
    chk("R11 port1 independent", rd1_data, 64'hAAAA_BBBB_CCCC_1234);
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk("R10 new value next cycle", rd0_data, 64'hDEAD_BEEF_0000_1111);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_full();
    t_dword();
    t_word();
    t_byte_low();
    t_high();
    t_ext();
    t_bit3();
    t_same_cycle();
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule